// File: doc/BRIEF.md
# Channel Byte Packer

This block sits in an I/O channel between a byte-wide device port and a 32-bit word memory port. It carries out one channel command word at a time. A command word gives a byte address, a byte count, a direction and four flags: chain, no-length-check, skip and program interrupt. In the into-memory direction, device bytes are merged into a word buffer and written back with byte enables. In the from-memory direction, whole words are fetched and handed to the device one byte at a time, in big-endian order.

When the count runs out, the block either finishes with channel-end status or asks for the next command word through a small load handshake. Command fetch, device selection and interrupt arbitration belong to the surrounding channel. The controller has six states:

- IDLE: after reset.
- XFER: moves bytes and decides when to end, chain or flush.
- FETCH: memory read outstanding.
- FLUSH: memory write of the dirty bytes outstanding.
- CHAIN: waiting for the next command word.
- DONE: finished; further device writes are swallowed.

The transitions are:

- IDLE→XFER and DONE→XFER on `ld_valid`.
- XFER→FETCH when a from-memory transfer finds the buffer empty.
- XFER→FLUSH when lane 3 is written, or before chaining or ending with dirty bytes.
- FETCH→XFER and FLUSH→XFER on `mem_ready`.
- XFER→CHAIN when the count is zero and chain is set.
- XFER→DONE when the count is zero and chain is clear, or on a device end.
- CHAIN→XFER on `ld_valid`.
- CHAIN→DONE on `ld_err`.

Top module: `chn_packer`

## Requirements
- R1: After reset the block is idle: `mem_req`, `chain_req`, `dev_stop`, `dev_wready`, `dev_rvalid`, `st_chend`, `st_ilen`, `st_prog` and `irq` are all 0.
- R2: Byte lane l (0..3) of a memory word occupies bits [31-8l:24-8l]. The byte at address a sits in lane a[1:0] of the word at a with its low two bits cleared. In the from-memory direction, the first byte returned is the lane selected by the start address.
- R3: Every byte moved decrements the count by one and advances the address by one. After lane 3 is consumed, the from-memory path fetches the next word.
- R4: In the into-memory direction, a byte in lane l sets `mem_be` bit 3-l, where `mem_be` bit i enables `mem_wdata[8i+7:8i]`. Memory bytes outside the transferred range keep their value. The dirty bytes are written out when lane 3 is filled, and before the block chains or ends. A write request always carries at least one enable bit.
- R5: When the count reaches zero with chain clear, `st_chend` is set and `dev_stop` rises. After that, no byte is offered, no memory request is made and `chain_req` stays low.
- R6: When the count reaches zero with chain set, `chain_req` is raised. `ld_valid` then loads a new address, count and flags, keeps the direction, and resumes the transfer. `ld_err` instead finishes the transfer without channel-end status.
- R7: With skip set in the into-memory direction, bytes are accepted and counted, but nothing is written to memory. Skip has no effect in the from-memory direction.
- R8: In the finished state, a device write is accepted and its data dropped. It sets `st_ilen` unless no-length-check is set.
- R9: A `dev_end` pulse during a transfer flushes dirty bytes and finishes the transfer with `st_chend`. It also sets `st_ilen` if the count is non-zero and no-length-check is clear.
- R10: A command word loaded with the program-interrupt flag sets `st_prog` and `irq` on the clock edge after it is accepted. A new start from IDLE or DONE clears all status bits and `irq`.
- R11: `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ready`. While `mem_req` is high, `dev_wready` and `dev_rvalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Command word present (start in IDLE/DONE, continuation in CHAIN) |
| ld_err | input | 1 | Next command word could not be loaded |
| ld_addr | input | AW | Byte address |
| ld_count | input | CW | Byte count |
| ld_into_mem | input | 1 | 1: device bytes go into memory, 0: memory bytes go to device |
| ld_chain | input | 1 | Chain to another command word when the count ends |
| ld_nolen | input | 1 | Suppress incorrect-length reporting |
| ld_skip | input | 1 | Count bytes without storing them |
| ld_prog | input | 1 | Program-controlled interrupt request |
| chain_req | output | 1 | Asks for the next command word |
| dev_wvalid | input | 1 | Device offers a byte for memory |
| dev_wdata | input | 8 | Byte from device |
| dev_wready | output | 1 | Byte from device accepted |
| dev_rvalid | output | 1 | Byte for device available |
| dev_rdata | output | 8 | Byte to device |
| dev_rready | input | 1 | Device takes the byte |
| dev_end | input | 1 | Device ends the transfer |
| dev_stop | output | 1 | Transfer finished |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | DW | Write data |
| mem_be | output | DW/8 | Byte enables, bit i for bits [8i+7:8i] |
| mem_rdata | input | DW | Read data |
| mem_ready | input | 1 | Access completes this cycle |
| st_chend | output | 1 | Channel-end status |
| st_ilen | output | 1 | Incorrect-length status |
| st_prog | output | 1 | Program-interrupt status |
| irq | output | 1 | Interrupt pending |

## Verification
The bench targets starts in mid-word and transfers that cross a word boundary. A lane mapping that is reversed or off by one would return or store the wrong byte, and wrong byte enables would clobber the neighbouring bytes left at their preset pattern. It also drives chains in which the dirty bytes must reach memory before `chain_req` rises, skip sequences that must leave memory untouched, and early device ends with and without length suppression. A design that flushed late, wrote skipped data or mis-set the length bit shows up at once against the bench's byte-level memory model. Writes after the finish, a failed chain load, and the clearing of the interrupt status on a new start round out the cases.

// File: rtl/chn_pkg.sv
package chn_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_XFER,
        S_FETCH,
        S_FLUSH,
        S_CHAIN,
        S_DONE
    } chn_state_e;

    typedef struct packed {
        logic chain;
        logic nolen;
        logic skip;
        logic prog;
    } chn_flags_t;

endpackage

// File: rtl/chn_lane.sv
module chn_lane #(
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int LW = $clog2(NB)
) (
    input  logic [LW-1:0] lane_i,
    input  logic [DW-1:0] word_i,
    input  logic [7:0]    byte_i,
    output logic [7:0]    byte_o,
    output logic [DW-1:0] word_o,
    output logic [NB-1:0] be_o
);
    // lane 0 is the most significant byte
    logic [LW-1:0] pos;
    assign pos    = LW'(NB - 1) - lane_i;
    assign byte_o = word_i[8*pos +: 8];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign be_o[g]          = (pos == LW'(g));
        assign word_o[8*g +: 8] = be_o[g] ? byte_i : word_i[8*g +: 8];
    end
endmodule

// File: rtl/chn_stat.sv
module chn_stat (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_end,
    input  logic set_len,
    input  logic set_prog,
    output logic end_o,
    output logic len_o,
    output logic prog_o,
    output logic irq_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_o  <= 1'b0;
            len_o  <= 1'b0;
            prog_o <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            if (clr) begin
                end_o  <= 1'b0;
                len_o  <= 1'b0;
                prog_o <= 1'b0;
                irq_o  <= 1'b0;
            end
            if (set_end) end_o <= 1'b1;
            if (set_len) len_o <= 1'b1;
            if (set_prog) begin
                prog_o <= 1'b1;
                irq_o  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/chn_packer.sv
module chn_packer #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_valid,
    input  logic            ld_err,
    input  logic [AW-1:0]   ld_addr,
    input  logic [CW-1:0]   ld_count,
    input  logic            ld_into_mem,
    input  logic            ld_chain,
    input  logic            ld_nolen,
    input  logic            ld_skip,
    input  logic            ld_prog,
    output logic            chain_req,
    input  logic            dev_wvalid,
    input  logic [7:0]      dev_wdata,
    output logic            dev_wready,
    output logic            dev_rvalid,
    output logic [7:0]      dev_rdata,
    input  logic            dev_rready,
    input  logic            dev_end,
    output logic            dev_stop,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [DW/8-1:0] mem_be,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ready,
    output logic            st_chend,
    output logic            st_ilen,
    output logic            st_prog,
    output logic            irq
);
    import chn_pkg::*;

    localparam int NB = DW / 8;
    localparam int LW = $clog2(NB);

    chn_state_e        state_q, state_d;
    logic [AW-1:0]     addr_q;
    logic [CW-1:0]     cnt_q;
    chn_flags_t        flg_q;
    logic              into_q;
    logic [DW-1:0]     buf_q;
    logic [NB-1:0]     be_q;
    logic              full_q;
    logic [AW-LW-1:0]  wa_q;
    logic              end_q;

    logic [7:0]        lane_byte;
    logic [DW-1:0]     lane_word;
    logic [NB-1:0]     lane_be;
    logic              start, reload, wr_hs, rd_hs, cnt_zero, dirty, last_lane;
    logic              set_end, set_len;

    chn_lane #(.DW(DW)) u_lane (
        .lane_i (addr_q[LW-1:0]),
        .word_i (buf_q),
        .byte_i (dev_wdata),
        .byte_o (lane_byte),
        .word_o (lane_word),
        .be_o   (lane_be)
    );

    assign start     = ld_valid && (state_q == S_IDLE || state_q == S_DONE);
    assign reload    = ld_valid && state_q == S_CHAIN;
    assign wr_hs     = state_q == S_XFER && dev_wvalid && dev_wready;
    assign rd_hs     = dev_rvalid && dev_rready;
    assign cnt_zero  = cnt_q == '0;
    assign dirty     = |be_q;
    assign last_lane = addr_q[LW-1:0] == LW'(NB - 1);

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (ld_valid) state_d = S_XFER;
            S_XFER: begin
                if (end_q || cnt_zero) begin
                    if (dirty)           state_d = S_FLUSH;
                    else if (end_q)      state_d = S_DONE;
                    else if (flg_q.chain) state_d = S_CHAIN;
                    else                 state_d = S_DONE;
                end else if (into_q) begin
                    if (wr_hs && !flg_q.skip && last_lane) state_d = S_FLUSH;
                end else if (!full_q) begin
                    state_d = S_FETCH;
                end
            end
            S_FETCH: if (mem_ready) state_d = S_XFER;
            S_FLUSH: if (mem_ready) state_d = S_XFER;
            S_CHAIN: begin
                if (ld_valid)    state_d = S_XFER;
                else if (ld_err) state_d = S_DONE;
            end
            S_DONE:  if (ld_valid) state_d = S_XFER;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        chain_req  = state_q == S_CHAIN;
        dev_stop   = state_q == S_DONE;
        dev_wready = (state_q == S_XFER && into_q && !end_q && !cnt_zero) ||
                     (state_q == S_DONE && into_q);
        dev_rvalid = state_q == S_XFER && !into_q && !end_q && !cnt_zero && full_q;
        dev_rdata  = lane_byte;
        mem_req    = state_q == S_FETCH || state_q == S_FLUSH;
        mem_we     = state_q == S_FLUSH;
        mem_addr   = (state_q == S_FLUSH) ? {wa_q, {LW{1'b0}}}
                                          : {addr_q[AW-1:LW], {LW{1'b0}}};
        mem_wdata  = buf_q;
        mem_be     = (state_q == S_FLUSH) ? be_q : '0;
    end

    assign set_end = state_q == S_XFER && state_d == S_DONE;
    assign set_len = (state_q == S_XFER && end_q && !dirty && !cnt_zero && !flg_q.nolen) ||
                     (state_q == S_DONE && into_q && dev_wvalid && !flg_q.nolen);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            flg_q  <= '0;
            into_q <= 1'b0;
            buf_q  <= '0;
            be_q   <= '0;
            full_q <= 1'b0;
            wa_q   <= '0;
            end_q  <= 1'b0;
        end else if (start || reload) begin
            addr_q <= ld_addr;
            cnt_q  <= ld_count;
            flg_q  <= {ld_chain, ld_nolen, ld_skip, ld_prog};
            full_q <= 1'b0;
            if (start) begin
                into_q <= ld_into_mem;
                be_q   <= '0;
                end_q  <= 1'b0;
            end
        end else begin
            if (flg_q.prog) flg_q.prog <= 1'b0;
            if (wr_hs) begin
                cnt_q  <= cnt_q - 1'b1;
                addr_q <= addr_q + 1'b1;
                if (!flg_q.skip) begin
                    buf_q <= lane_word;
                    be_q  <= be_q | lane_be;
                    wa_q  <= addr_q[AW-1:LW];
                end
            end
            if (rd_hs) begin
                cnt_q  <= cnt_q - 1'b1;
                addr_q <= addr_q + 1'b1;
                if (last_lane) full_q <= 1'b0;
            end
            if (state_q == S_FETCH && mem_ready) begin
                buf_q  <= mem_rdata;
                full_q <= 1'b1;
            end
            if (state_q == S_FLUSH && mem_ready) be_q <= '0;
            if (dev_end && (state_q == S_XFER || state_q == S_FETCH ||
                            state_q == S_FLUSH || state_q == S_CHAIN)) end_q <= 1'b1;
            if (set_end) end_q <= 1'b0;
        end
    end

    chn_stat u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start),
        .set_end  (set_end),
        .set_len  (set_len),
        .set_prog (flg_q.prog),
        .end_o    (st_chend),
        .len_o    (st_ilen),
        .prog_o   (st_prog),
        .irq_o    (irq)
    );

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)) else $error("mem hold"); // R11
    AST_BYTE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !dev_wready && !dev_rvalid) else $error("byte stall"); // R11
    AST_FLUSH_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_be != '0) else $error("empty flush"); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rvalid && dev_rready |=> cnt_q == $past(cnt_q) - 1'b1) else $error("count step"); // R3
    AST_PROG_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_prog) |-> irq) else $error("prog irq"); // R10
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dev_stop |-> !dev_rvalid && !mem_req && !chain_req) else $error("stop quiet"); // R5
endmodule

// File: tb/chn_packer_bench.sv
`timescale 1ns/1ps
module chn_packer_bench;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, ld_valid, ld_err, ld_into_mem, ld_chain, ld_nolen, ld_skip, ld_prog;
    logic [AW-1:0] ld_addr;
    logic [CW-1:0] ld_count;
    logic chain_req, dev_wvalid, dev_wready, dev_rvalid, dev_rready, dev_end, dev_stop;
    logic [7:0] dev_wdata, dev_rdata;
    logic mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [3:0] mem_be;
    logic st_chend, st_ilen, st_prog, irq;

    chn_packer #(.AW(AW), .CW(CW), .DW(DW)) u_chn_packer (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_err(ld_err),
        .ld_addr(ld_addr), .ld_count(ld_count), .ld_into_mem(ld_into_mem),
        .ld_chain(ld_chain), .ld_nolen(ld_nolen), .ld_skip(ld_skip), .ld_prog(ld_prog),
        .chain_req(chain_req), .dev_wvalid(dev_wvalid), .dev_wdata(dev_wdata),
        .dev_wready(dev_wready), .dev_rvalid(dev_rvalid), .dev_rdata(dev_rdata),
        .dev_rready(dev_rready), .dev_end(dev_end), .dev_stop(dev_stop),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .st_chend(st_chend), .st_ilen(st_ilen), .st_prog(st_prog), .irq(irq)
    );

    // behavioural word memory, big-endian bytes
    logic [31:0] mem [0:63];
    function automatic logic [7:0] orig(int a);
        return 8'(a) ^ 8'hA5;
    endfunction
    function automatic logic [7:0] get_byte(int a);
        return mem[a/4][8*(3-(a%4)) +: 8];
    endfunction
    assign mem_rdata = mem[mem_addr[7:2]];
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            for (int i = 0; i < 64; i++)
                mem[i] <= {orig(4*i), orig(4*i+1), orig(4*i+2), orig(4*i+3)};
        end else if (mem_req && mem_ready) begin
            mem_ready <= 1'b0;
            if (mem_we)
                for (int i = 0; i < 4; i++)
                    if (mem_be[i]) mem[mem_addr[7:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
        end else begin
            mem_ready <= mem_req;
        end
    end

    int errs = 0;
    int checks = 0;
    bit finished = 0;

    task automatic chk_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock protocol monitor
    logic prev_wait;
    logic [AW-1:0] prev_addr;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) chk_eq("R11 stall", {dev_wready, dev_rvalid}, 0);
            if (prev_wait) chk_eq("R11 hold", {mem_req, mem_addr}, {1'b1, prev_addr});
            prev_wait = mem_req && !mem_ready;
            prev_addr = mem_addr;
        end else begin
            prev_wait = 1'b0;
            prev_addr = '0;
        end
    end

    task automatic load(int a, int n, bit into, bit ch, bit nl, bit sk, bit pr);
        @(negedge clk);
        ld_valid = 1; ld_addr = AW'(a); ld_count = CW'(n); ld_into_mem = into;
        ld_chain = ch; ld_nolen = nl; ld_skip = sk; ld_prog = pr;
        @(negedge clk);
        ld_valid = 0;
    endtask

    task automatic send_byte(logic [7:0] b);
        @(negedge clk);
        dev_wvalid = 1; dev_wdata = b;
        #1;
        while (!dev_wready) begin @(negedge clk); #1; end
        @(negedge clk);
        dev_wvalid = 0;
    endtask

    task automatic recv_byte(int a, string req);
        @(negedge clk);
        dev_rready = 1;
        #1;
        while (!dev_rvalid) begin @(negedge clk); #1; end
        chk_eq(req, dev_rdata, get_byte(a));
        @(negedge clk);
        dev_rready = 0;
    endtask

    task automatic wait_stop();
        @(negedge clk); #1;
        while (!dev_stop) begin @(negedge clk); #1; end
    endtask

    task automatic wait_chain();
        @(negedge clk); #1;
        while (!chain_req) begin @(negedge clk); #1; end
    endtask

    task automatic pulse_end();
        @(negedge clk); dev_end = 1;
        @(negedge clk); dev_end = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errs++;
        $display("FAIL R11 watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        rst_n = 0; ld_valid = 0; ld_err = 0; ld_addr = '0; ld_count = '0;
        ld_into_mem = 0; ld_chain = 0; ld_nolen = 0; ld_skip = 0; ld_prog = 0;
        dev_wvalid = 0; dev_wdata = '0; dev_rready = 0; dev_end = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R1 reset state
        chk_eq("R1 requests", {mem_req, chain_req, dev_stop, dev_wready, dev_rvalid}, 0);
        chk_eq("R1 status", {st_chend, st_ilen, st_prog, irq}, 0);

        // R4 R2 R5: into memory, mid-word start crossing a word
        load(8'h11, 6, 1, 0, 0, 0, 0);
        for (int k = 0; k < 6; k++) send_byte(8'hC0 + 8'(k));
        wait_stop();
        chk_eq("R5 chend", st_chend, 1);
        chk_eq("R5 no ilen", st_ilen, 0);
        for (int a = 8'h10; a < 8'h18; a++)
            chk_eq("R4 lanes", get_byte(a),
                   (a >= 8'h11 && a <= 8'h16) ? 8'hC0 + a - 8'h11 : orig(a));
        // R8 write after finish
        send_byte(8'h77);
        @(negedge clk); #1;
        chk_eq("R8 ilen", st_ilen, 1);
        chk_eq("R8 dropped", get_byte(8'h17), orig(8'h17));

        // R2 R3: from memory across a word boundary
        load(8'h22, 5, 0, 0, 0, 0, 0);
        for (int a = 8'h22; a < 8'h27; a++) recv_byte(a, "R2 R3 byte order");
        wait_stop();
        chk_eq("R5 chend read", st_chend, 1);
        chk_eq("R10 cleared ilen", st_ilen, 0);
        repeat (3) @(negedge clk);
        chk_eq("R5 no more bytes", {dev_rvalid, mem_req}, 0);

        // R6 R10: chain with flush before the request
        load(8'h31, 2, 1, 1, 0, 0, 0);
        send_byte(8'hD0); send_byte(8'hD1);
        wait_chain();
        chk_eq("R6 chain_req", chain_req, 1);
        chk_eq("R4 flush before chain", {get_byte(8'h31), get_byte(8'h32)}, 16'hD0D1);
        load(8'h3A, 2, 0, 0, 0, 0, 1);
        send_byte(8'hD2); send_byte(8'hD3);
        wait_stop();
        chk_eq("R6 chained data", {get_byte(8'h39), get_byte(8'h3A), get_byte(8'h3B), get_byte(8'h3C)},
               {orig(8'h39), 8'hD2, 8'hD3, orig(8'h3C)});
        chk_eq("R6 chend", st_chend, 1);
        chk_eq("R10 prog irq", {st_prog, irq}, 2'b11);

        // R7: skip then chain into a real write
        load(8'h40, 3, 1, 1, 0, 1, 0);
        @(negedge clk);
        chk_eq("R10 clear on start", {st_prog, irq}, 0);
        for (int k = 0; k < 3; k++) send_byte(8'hEE);
        wait_chain();
        chk_eq("R7 skip leaves memory",
               {get_byte(8'h40), get_byte(8'h41), get_byte(8'h42)},
               {orig(8'h40), orig(8'h41), orig(8'h42)});
        load(8'h44, 1, 1, 0, 0, 0, 0);
        send_byte(8'hE0);
        wait_stop();
        chk_eq("R7 after skip", get_byte(8'h44), 8'hE0);

        // R9: early end, length checked
        load(8'h50, 5, 1, 0, 0, 0, 0);
        send_byte(8'hF0); send_byte(8'hF1);
        pulse_end();
        wait_stop();
        chk_eq("R9 status", {st_chend, st_ilen}, 2'b11);
        chk_eq("R9 flushed", {get_byte(8'h50), get_byte(8'h51), get_byte(8'h52)},
               {8'hF0, 8'hF1, orig(8'h52)});

        // R9: early end, length suppressed
        load(8'h60, 4, 0, 0, 1, 0, 0);
        recv_byte(8'h60, "R2 read");
        pulse_end();
        wait_stop();
        chk_eq("R9 suppressed", {st_chend, st_ilen}, 2'b10);

        // R6: failed chain load
        load(8'h70, 1, 1, 1, 0, 0, 0);
        send_byte(8'h9C);
        wait_chain();
        @(negedge clk); ld_err = 1;
        @(negedge clk); ld_err = 0;
        wait_stop();
        chk_eq("R6 err no chend", st_chend, 0);
        chk_eq("R6 data kept", get_byte(8'h70), 8'h9C);

        // R8: write after finish with suppression
        load(8'h78, 1, 1, 0, 1, 0, 0);
        send_byte(8'h5B);
        wait_stop();
        send_byte(8'h66);
        @(negedge clk); #1;
        chk_eq("R8 suppressed", st_ilen, 0);
        chk_eq("R8 dropped", {get_byte(8'h78), get_byte(8'h79)}, {8'h5B, orig(8'h79)});

        summary();
    end
endmodule